// File: doc/BRIEF.md
# Audio Controller Interrupt Status Aggregator

This block gathers the sticky event flags of an audio controller into a single level-sensitive interrupt line. The buffer engines pulse set inputs for three kinds of source: the response ring (a response-interrupt flag and an overrun flag), the per-codec wake events, and each stream's status (buffer completion, FIFO error, descriptor error). The flags are held in status registers that software clears by writing ones.

A summary register is formed from the status every cycle. It holds one bit per stream for buffer completion, a controller bit for ring and enabled wake events, and a global bit for "anything pending". The interrupt line is driven when the global enable is set and at least one non-global summary bit is also enabled in the control register. A simple register port with byte enables gives software read access to all registers and write access to the control, wake-enable and status registers.

Register word map (byte address = 4 x word): control 0, summary 1, wake enable 2, wake status 3, ring status 4, stream n status 16+n. Streams 0 to 3 are input streams and 4 to 7 are output streams.

Top module: `aud_irq_agg`

## Requirements
- R1: Ring status bit 0 (response interrupt) or bit 2 (overrun) being set makes summary bit 30 (controller) read as one.
- R2: Summary bit 30 also reads one when any wake status bit [14:0] is set together with the same bit of the wake-enable register; a wake status bit whose enable is clear does not set it.
- R3: Stream n status bit 2 (buffer completion) sets summary bit n; stream status bits 3 (FIFO error) and 4 (descriptor error) do not affect the summary.
- R4: Summary bit 31 (global) reads one exactly when any summary bit in [30:0] is one.
- R5: The interrupt output is high only when control bit 31 (global enable) is set and summary bits [30:0] ANDed with control bits [30:0] are nonzero; control bit 30 enables the controller bit, control bits [7:0] enable the stream bits.
- R6: A write to wake status, ring status or a stream status register clears exactly the clearable bits written as one in enabled byte lanes (wake [14:0], ring bits 0 and 2, stream bits 2, 3, 4); every other bit keeps its value.
- R7: Status bits are sticky: a set pulse holds the bit until it is cleared, and a set pulse in the same cycle as a clearing write leaves the bit set.
- R8: Writes to the summary register have no effect on its contents.
- R9: After reset all control, enable and status registers read zero and the interrupt output is low.
- R10: The control register keeps only bits 31, 30 and [7:0], the wake-enable register keeps bits [14:0]; writes update only bytes whose enable is set, and only word-aligned addresses are decoded.
- R11: A clearing write that removes the last enabled source drops the interrupt output in the cycle right after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ring_set | input | 2 | Ring set pulses: [0] response interrupt, [1] overrun |
| wake_set | input | NCODEC | Wake status set pulses, one per codec |
| strm_set | input | 3*NSTRM | Per stream n: [3n] buffer completion, [3n+1] FIFO error, [3n+2] descriptor error |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Byte address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte lane enables for writes |
| reg_rdata | output | 32 | Read data at reg_addr (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is a set pulse landing on the very clock edge where software clears the same bit, because the two sides come from different agents; the bench drives a buffer-completion pulse and a clearing write to the same stream in one cycle and reads the bit afterwards. Partial clears are also awkward: a wake status with bits in both byte lanes is cleared with only the upper lane enabled, and the gating of the line is tested by holding a source pending while the global enable or the individual enable is removed, so the summary stays nonzero while the line must fall.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;

  // word indices of the register map
  localparam int W_CTRL  = 0;
  localparam int W_SUM   = 1;
  localparam int W_WEN   = 2;
  localparam int W_WSTS  = 3;
  localparam int W_RING  = 4;
  localparam int W_STRM0 = 16;

  // summary / control bit positions
  localparam int BIT_CIS = 30;
  localparam int BIT_GIS = 31;

  // ring status layout
  localparam int RING_W  = 3;
  localparam int RB_RESP = 0;
  localparam int RB_OVR  = 2;

  // stream status layout
  localparam int STRM_W  = 5;
  localparam int SB_BC   = 2;
  localparam int SB_FE   = 3;
  localparam int SB_DE   = 4;

  // expand byte enables to a bit mask
  function automatic logic [31:0] be_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

endpackage

// File: rtl/aud_irq_w1c.sv
module aud_irq_w1c #(
  parameter int               W        = 8,
  parameter logic [W-1:0]     CLR_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q;
  logic [W-1:0] q_nxt;
  logic [W-1:0] clr_eff;
  logic         upd;

  always_comb begin
    clr_eff = clr_i & CLR_MASK;
    q_nxt   = (q & ~clr_eff) | set_i;
    upd     = (|set_i) | (|clr_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= q_nxt;
  end

  assign q_o = q;

  // R6: bits written as one (and not set at the same time) are gone afterwards
  a_r6_clear_written: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & CLR_MASK)) |=> ((q_o & $past(clr_i & CLR_MASK & ~set_i)) == '0));

  // R6: bits not written as one keep their value when nothing sets them
  a_r6_hold_unwritten: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i == '0) |=> ((q_o & ~$past(clr_i & CLR_MASK)) ==
                       ($past(q_o) & ~$past(clr_i & CLR_MASK))));

  // R7: a set pulse always lands, even against a clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/aud_irq_ctl.sv
module aud_irq_ctl #(
  parameter int NSTRM  = 8,
  parameter int NCODEC = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_wen,
  input  logic [31:0]       wdata,
  input  logic [31:0]       bmask,
  output logic [31:0]       ctrl_o,
  output logic [NCODEC-1:0] wen_o
);
  import aud_irq_pkg::*;

  localparam logic [31:0] CTRL_RW = (32'(1) << BIT_GIS) | (32'(1) << BIT_CIS) |
                                    ((32'(1) << NSTRM) - 32'(1));

  logic [31:0]       ctrl, ctrl_nxt;
  logic [NCODEC-1:0] wen,  wen_nxt;
  logic [31:0]       ctrl_wm;
  logic [NCODEC-1:0] wen_wm;

  always_comb begin
    ctrl_wm  = bmask & CTRL_RW;
    wen_wm   = bmask[NCODEC-1:0];
    ctrl_nxt = (ctrl & ~ctrl_wm) | (wdata & ctrl_wm);
    wen_nxt  = (wen & ~wen_wm) | (wdata[NCODEC-1:0] & wen_wm);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (wr_ctrl) ctrl <= ctrl_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wen <= '0;
    else if (wr_wen) wen <= wen_nxt;
  end

  assign ctrl_o = ctrl;
  assign wen_o  = wen;

  // R10: control and enable change only on their own writes
  a_r10_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_o));
  a_r10_wen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_wen |=> $stable(wen_o));

endmodule

// File: rtl/aud_irq_sum.sv
module aud_irq_sum #(
  parameter int NSTRM  = 8,
  parameter int NCODEC = 15
) (
  input  logic [1:0]        ring_flags_i,
  input  logic [NCODEC-1:0] wake_sts_i,
  input  logic [NCODEC-1:0] wake_en_i,
  input  logic [NSTRM-1:0]  strm_bc_i,
  input  logic [31:0]       ctrl_i,
  output logic [31:0]       sum_o,
  output logic              irq_o
);
  import aud_irq_pkg::*;

  logic        cis;
  logic [30:0] low;

  always_comb begin
    cis = (|ring_flags_i) | (|(wake_sts_i & wake_en_i));
    low = '0;
    low[NSTRM-1:0] = strm_bc_i;
    low[BIT_CIS]   = cis;
    sum_o = {(|low), low};
    irq_o = ctrl_i[BIT_GIS] & (|(low & ctrl_i[30:0]));
  end

endmodule

// File: rtl/aud_irq_agg.sv
module aud_irq_agg #(
  parameter int NIN    = 4,
  parameter int NOUT   = 4,
  parameter int NCODEC = 15,
  parameter int AW     = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                ring_set,
  input  logic [NCODEC-1:0]         wake_set,
  input  logic [3*(NIN+NOUT)-1:0]   strm_set,
  input  logic                      reg_wr,
  input  logic [AW-1:0]             reg_addr,
  input  logic [31:0]               reg_wdata,
  input  logic [3:0]                reg_be,
  output logic [31:0]               reg_rdata,
  output logic                      irq
);
  import aud_irq_pkg::*;

  localparam int NSTRM = NIN + NOUT;
  localparam logic [RING_W-1:0] RING_CLR = (RING_W'(1) << RB_RESP) | (RING_W'(1) << RB_OVR);
  localparam logic [STRM_W-1:0] STRM_CLR = (STRM_W'(1) << SB_BC) | (STRM_W'(1) << SB_FE) |
                                           (STRM_W'(1) << SB_DE);

  // reset: asynchronous assertion, synchronous release
  logic rst_s1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  // address decode
  logic [AW-3:0] widx;
  logic          aligned;
  logic [31:0]   bmask;
  logic [31:0]   wclr;
  logic          wr_ctrl, wr_wen, wr_wsts, wr_ring;
  logic [NSTRM-1:0] wr_strm;

  always_comb begin
    widx    = reg_addr[AW-1:2];
    aligned = (reg_addr[1:0] == 2'b00);
    bmask   = be_mask(reg_be);
    wclr    = reg_wdata & bmask;
    wr_ctrl = reg_wr && aligned && (int'(widx) == W_CTRL);
    wr_wen  = reg_wr && aligned && (int'(widx) == W_WEN);
    wr_wsts = reg_wr && aligned && (int'(widx) == W_WSTS);
    wr_ring = reg_wr && aligned && (int'(widx) == W_RING);
    for (int n = 0; n < NSTRM; n++)
      wr_strm[n] = reg_wr && aligned && (int'(widx) == W_STRM0 + n);
  end

  // control and wake enable
  logic [31:0]       ctrl;
  logic [NCODEC-1:0] wake_en;

  aud_irq_ctl #(.NSTRM(NSTRM), .NCODEC(NCODEC)) u_ctl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_ctrl(wr_ctrl),
    .wr_wen (wr_wen),
    .wdata  (reg_wdata),
    .bmask  (bmask),
    .ctrl_o (ctrl),
    .wen_o  (wake_en)
  );

  // wake status
  logic [NCODEC-1:0] wake_q;
  aud_irq_w1c #(.W(NCODEC), .CLR_MASK({NCODEC{1'b1}})) u_wake (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .set_i(wake_set),
    .clr_i(wr_wsts ? wclr[NCODEC-1:0] : '0),
    .q_o  (wake_q)
  );

  // ring status
  logic [RING_W-1:0] ring_setv;
  logic [RING_W-1:0] ring_q;
  always_comb begin
    ring_setv          = '0;
    ring_setv[RB_RESP] = ring_set[0];
    ring_setv[RB_OVR]  = ring_set[1];
  end

  aud_irq_w1c #(.W(RING_W), .CLR_MASK(RING_CLR)) u_ring (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .set_i(ring_setv),
    .clr_i(wr_ring ? wclr[RING_W-1:0] : '0),
    .q_o  (ring_q)
  );

  // stream status, one register per stream
  logic [STRM_W-1:0] strm_q [NSTRM];
  logic [NSTRM-1:0]  strm_bc;

  for (genvar n = 0; n < NSTRM; n++) begin : g_strm
    logic [STRM_W-1:0] setv;
    always_comb begin
      setv        = '0;
      setv[SB_BC] = strm_set[3*n];
      setv[SB_FE] = strm_set[3*n+1];
      setv[SB_DE] = strm_set[3*n+2];
    end

    aud_irq_w1c #(.W(STRM_W), .CLR_MASK(STRM_CLR)) u_sts (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .set_i(setv),
      .clr_i(wr_strm[n] ? wclr[STRM_W-1:0] : '0),
      .q_o  (strm_q[n])
    );

    assign strm_bc[n] = strm_q[n][SB_BC];
  end

  // summary and line
  logic [31:0] sum;
  aud_irq_sum #(.NSTRM(NSTRM), .NCODEC(NCODEC)) u_sum (
    .ring_flags_i({ring_q[RB_OVR], ring_q[RB_RESP]}),
    .wake_sts_i  (wake_q),
    .wake_en_i   (wake_en),
    .strm_bc_i   (strm_bc),
    .ctrl_i      (ctrl),
    .sum_o       (sum),
    .irq_o       (irq)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (aligned) begin
      case (int'(widx))
        W_CTRL:  reg_rdata = ctrl;
        W_SUM:   reg_rdata = sum;
        W_WEN:   reg_rdata[NCODEC-1:0] = wake_en;
        W_WSTS:  reg_rdata[NCODEC-1:0] = wake_q;
        W_RING:  reg_rdata[RING_W-1:0] = ring_q;
        default: begin
          for (int n = 0; n < NSTRM; n++)
            if (int'(widx) == W_STRM0 + n) reg_rdata[STRM_W-1:0] = strm_q[n];
        end
      endcase
    end
  end

  // R1: a pending ring flag shows in the controller bit
  a_r1_ring_to_cis: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ring_q[RB_RESP] || ring_q[RB_OVR]) |-> sum[BIT_CIS]);

  // R2: an enabled pending wake event shows in the controller bit
  a_r2_wake_to_cis: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|(wake_q & wake_en)) |-> sum[BIT_CIS]);

  // R3: buffer completion of stream 0 shows in summary bit 0
  a_r3_strm0_bc: assert property (@(posedge clk) disable iff (!rst_sync_n)
    strm_q[0][SB_BC] |-> sum[0]);

  // R4: the global bit has a real source behind it
  a_r4_gis_has_source: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sum[BIT_GIS] |-> ((|ring_q) || (|(wake_q & wake_en)) || (|strm_bc)));

  // R5: no line without the global enable
  a_r5_irq_needs_gie: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq |-> ctrl[BIT_GIS]);

  // R9: line low while reset is held
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_sync_n |=> !irq);

endmodule

// File: tb/sim_aud_irq_agg.sv
module sim_aud_irq_agg;

  localparam int NCODEC = 15;
  localparam int NSTRM  = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [1:0]        ring_set;
  logic [NCODEC-1:0] wake_set;
  logic [3*NSTRM-1:0] strm_set;
  logic              reg_wr;
  logic [7:0]        reg_addr;
  logic [31:0]       reg_wdata;
  logic [3:0]        reg_be;
  logic [31:0]       reg_rdata;
  logic              irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  aud_irq_agg u0 (
    .clk(clk), .rst_n(rst_n), .ring_set(ring_set), .wake_set(wake_set),
    .strm_set(strm_set), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata), .irq(irq)
  );

  localparam logic [7:0] A_CTRL = 8'h00, A_SUM = 8'h04, A_WEN = 8'h08,
                         A_WSTS = 8'h0C, A_RING = 8'h10;
  function automatic logic [7:0] a_strm(input int n);
    return 8'(8'h40 + 4*n);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; reg_be = '0;
  endtask

  task automatic pulse_strm(input int n, input int kind);
    @(negedge clk);
    strm_set[3*n+kind] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    strm_set = '0;
  endtask

  task automatic pulse_ring(input logic [1:0] v);
    @(negedge clk);
    ring_set = v;
    @(posedge clk);
    @(negedge clk);
    ring_set = '0;
  endtask

  task automatic pulse_wake(input logic [NCODEC-1:0] v);
    @(negedge clk);
    wake_set = v;
    @(posedge clk);
    @(negedge clk);
    wake_set = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R9 irq", 32'(irq), 0);
    rd(A_CTRL, d); chk("R9 ctrl", d, 0);
    rd(A_SUM, d);  chk("R9 sum", d, 0);
    rd(A_WEN, d);  chk("R9 wake en", d, 0);
    rd(A_WSTS, d); chk("R9 wake sts", d, 0);
    rd(A_RING, d); chk("R9 ring", d, 0);
    rd(a_strm(7), d); chk("R9 stream7", d, 0);
  endtask

  task automatic t_ctrl_rw();
    logic [31:0] d;
    wr(A_CTRL, 32'hFFFF_FFFF, 4'hF);
    rd(A_CTRL, d); chk("R10 ctrl kept bits", d, 32'hC000_00FF);
    wr(A_CTRL, 32'h0, 4'h1);
    rd(A_CTRL, d); chk("R10 ctrl byte lane", d, 32'hC000_0000);
    wr(8'h01, 32'h0, 4'hF);
    rd(A_CTRL, d); chk("R10 unaligned ignored", d, 32'hC000_0000);
    wr(A_WEN, 32'hFFFF_FFFF, 4'h2);
    rd(A_WEN, d); chk("R10 wake en upper lane", d, 32'h0000_7F00);
    wr(A_CTRL, 32'h0, 4'hF);
    wr(A_WEN, 32'h0, 4'hF);
  endtask

  task automatic t_stream();
    logic [31:0] d;
    wr(A_CTRL, 32'h8000_0020, 4'hF);
    chk("R5 idle line", 32'(irq), 0);
    pulse_strm(5, 0);
    rd(a_strm(5), d); chk("R3 stream5 status", d, 32'h04);
    rd(A_SUM, d); chk("R3 R4 summary", d, 32'h8000_0020);
    chk("R5 line on", 32'(irq), 1);
    pulse_strm(2, 1);
    pulse_strm(2, 2);
    rd(a_strm(2), d); chk("R3 stream2 errors", d, 32'h18);
    rd(A_SUM, d); chk("R3 errors not summarised", d, 32'h8000_0020);
  endtask

  task automatic t_gate();
    logic [31:0] d;
    wr(A_CTRL, 32'h0000_0020, 4'hF);
    chk("R5 no global enable", 32'(irq), 0);
    rd(A_SUM, d); chk("R5 summary kept", d, 32'h8000_0020);
    wr(A_CTRL, 32'h8000_0010, 4'hF);
    chk("R5 source not enabled", 32'(irq), 0);
    wr(A_CTRL, 32'h8000_0020, 4'hF);
    chk("R5 line back", 32'(irq), 1);
  endtask

  task automatic t_w1c_stream();
    logic [31:0] d;
    wr(a_strm(5), 32'h0, 4'hF);
    rd(a_strm(5), d); chk("R6 zero write keeps", d, 32'h04);
    wr(a_strm(5), 32'hFF, 4'h0);
    rd(a_strm(5), d); chk("R6 disabled lane keeps", d, 32'h04);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a_strm(5); reg_wdata = 32'h04; reg_be = 4'h1;
    @(posedge clk);
    #1;
    chk("R11 line drops after edge", 32'(irq), 0);
    @(negedge clk);
    reg_wr = 1'b0;
    rd(a_strm(5), d); chk("R6 stream5 cleared", d, 0);
    wr(a_strm(2), 32'h08, 4'hF);
    rd(a_strm(2), d); chk("R6 only FIFO error cleared", d, 32'h10);
    wr(a_strm(2), 32'hFF, 4'hF);
    rd(a_strm(2), d); chk("R6 stream2 cleared", d, 0);
    rd(A_SUM, d); chk("R4 summary empty", d, 0);
  endtask

  task automatic t_ring();
    logic [31:0] d;
    wr(A_CTRL, 32'hC000_0000, 4'hF);
    pulse_ring(2'b01);
    rd(A_RING, d); chk("R1 response flag", d, 32'h01);
    rd(A_SUM, d); chk("R1 controller bit", d, 32'hC000_0000);
    chk("R5 line from ring", 32'(irq), 1);
    wr(A_RING, 32'h01, 4'h1);
    chk("R6 R11 ring clear drops line", 32'(irq), 0);
    pulse_ring(2'b10);
    rd(A_RING, d); chk("R1 overrun flag", d, 32'h04);
    rd(A_SUM, d); chk("R1 overrun summary", d, 32'hC000_0000);
    wr(A_RING, 32'h04, 4'h1);
    rd(A_RING, d); chk("R6 ring cleared", d, 0);
  endtask

  task automatic t_wake();
    logic [31:0] d;
    pulse_wake(15'h1008);
    rd(A_WSTS, d); chk("R2 wake status", d, 32'h1008);
    rd(A_SUM, d); chk("R2 disabled wake", d, 0);
    wr(A_WEN, 32'h0008, 4'h3);
    rd(A_SUM, d); chk("R2 enabled wake", d, 32'hC000_0000);
    chk("R5 line from wake", 32'(irq), 1);
    wr(A_WSTS, 32'hFFFF, 4'h2);
    rd(A_WSTS, d); chk("R6 wake upper lane only", d, 32'h0008);
    wr(A_WSTS, 32'h0008, 4'h1);
    rd(A_WSTS, d); chk("R6 wake cleared", d, 0);
    chk("R11 wake line low", 32'(irq), 0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    pulse_strm(1, 0);
    pulse_strm(1, 0);
    rd(a_strm(1), d); chk("R7 sticky", d, 32'h04);
    @(negedge clk);
    strm_set[3] = 1'b1;
    reg_wr = 1'b1; reg_addr = a_strm(1); reg_wdata = 32'h04; reg_be = 4'hF;
    @(posedge clk);
    @(negedge clk);
    strm_set = '0; reg_wr = 1'b0;
    rd(a_strm(1), d); chk("R7 set beats clear", d, 32'h04);
  endtask

  task automatic t_sum_ro();
    logic [31:0] d;
    wr(A_SUM, 32'h0, 4'hF);
    rd(A_SUM, d); chk("R8 summary write ignored", d, 32'h8000_0002);
    wr(A_SUM, 32'hFFFF_FFFF, 4'hF);
    rd(A_SUM, d); chk("R8 summary ones ignored", d, 32'h8000_0002);
  endtask

  initial begin
    rst_n = 1'b0; ring_set = '0; wake_set = '0; strm_set = '0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; reg_be = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ctrl_rw();
    t_stream();
    t_gate();
    t_w1c_stream();
    t_ring();
    t_wake();
    t_collide();
    t_sum_ro();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule